// File: doc/BRIEF.md
# Lockstep Pin-Comparison Unit

This unit lets two identical cores run side by side, one acting as the master and one as the checker. A role strap is sampled while reset is held. The value present on the last reset clock edge decides the role, and that role is kept until the next reset. As master, the unit passes the core's own output enables straight to the pin drivers, so the core behaves normally.

As checker, the unit withdraws the drive from every compared pin. Both parts see the same shared pins, so the checker samples the values the master drives there. Every cycle it compares those values against the values its own core computed for the same instruction stream. A small exempt set of pins, chosen by a parameter mask, stays driven by the checker and is never compared. A test-data output is an example of such a pin. The error flag itself is a separate output that the checker always drives.

A bit is compared only in a cycle where the checker's core would have driven it. Any difference on a compared bit raises the registered error flag one cycle later. A build option selects the flag's behaviour. In the pulse variant it clears as soon as the mismatch is gone. In the sticky variant it holds until reset.

Top module: `lockstep_cmp`

## Requirements
- R1: On the last rising clock edge with rst_n low, the unit latches its role from strap_chk: 1 selects checker and 0 selects master.
- R2: While rst_n is high, changes on strap_chk have no effect on the latched role. This is observable on pin_oe.
- R3: In master role, pin_oe equals core_oe on every bit.
- R4: In checker role, pin_oe equals core_oe on the bits set in EXEMPT_MASK and is 0 on all other bits.
- R5: In checker role, if any bit has core_oe = 1, has EXEMPT_MASK = 0, and has pin_in different from core_out at a rising edge, chk_err is 1 in the following cycle.
- R6: A bit whose core_oe is 0 in a cycle is not compared, so a difference on it leaves chk_err at 0.
- R7: A bit set in EXEMPT_MASK is never compared, so a difference on it leaves chk_err at 0.
- R8: In master role no comparison is made, and chk_err stays 0 whatever pin_in carries.
- R9: chk_err is 0 in the cycle after any rising edge at which rst_n is low.
- R10: With STICKY = 0, chk_err is 0 in the cycle after an edge that sees no mismatch. With STICKY = 1, chk_err stays 1 once set, until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; the role strap is sampled while this is low |
| strap_chk | input | 1 | Role strap: 1 = checker, 0 = master |
| core_out | input | WIDTH | Values the local core computes for the pins this cycle |
| core_oe | input | WIDTH | Per-bit output enable computed by the local core |
| pin_in | input | WIDTH | Values sampled from the shared pins |
| pin_oe | output | WIDTH | Per-bit drive enable sent to the pin buffers |
| chk_err | output | 1 | Registered comparison error flag |

## Verification
The bench builds two instances with WIDTH = 8 and EXEMPT_MASK = 8'h81, so one exempt bit sits at each end of the vector. One instance uses STICKY = 0 and the other uses STICKY = 1, and both receive the same stimulus. This lets one mismatch sequence show the pulse variant clearing while the sticky variant holds. The narrow width keeps every bit pattern readable. The two exempt bits show that masking works at both vector boundaries. Enable-masked mismatches show that disabled bits are skipped.

// File: rtl/lc_pkg.sv
package lc_pkg;
   typedef enum logic {
      ROLE_MASTER  = 1'b0,
      ROLE_CHECKER = 1'b1
   } role_e;
endpackage

// File: rtl/lc_role.sv
// Role latch: follows the strap while reset is held and freezes once reset is released.
module lc_role
   import lc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  strap_chk,
   output role_e role_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         role_q <= strap_chk ? ROLE_CHECKER : ROLE_MASTER;
   end
endmodule

// File: rtl/lc_drive.sv
// Drive gating: exempt bits always follow the core; other bits float in checker role.
module lc_drive #(
   parameter int              WIDTH       = 32,
   parameter logic [WIDTH-1:0] EXEMPT_MASK = '0
) (
   input  logic             is_chk,
   input  logic [WIDTH-1:0] core_oe,
   output logic [WIDTH-1:0] pin_oe
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (EXEMPT_MASK[i]) begin : g_keep
         assign pin_oe[i] = core_oe[i];
      end else begin : g_gate
         assign pin_oe[i] = core_oe[i] & ~is_chk;
      end
   end
endmodule

// File: rtl/lc_compare.sv
// Comparator and registered error flag; STICKY selects the pulse or the hold variant.
module lc_compare #(
   parameter int              WIDTH       = 32,
   parameter logic [WIDTH-1:0] EXEMPT_MASK = '0,
   parameter bit              STICKY      = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_chk,
   input  logic [WIDTH-1:0] core_out,
   input  logic [WIDTH-1:0] core_oe,
   input  logic [WIDTH-1:0] pin_in,
   output logic             err_q
);
   localparam logic [WIDTH-1:0] CMP_MASK = ~EXEMPT_MASK;

   logic [WIDTH-1:0] diff;
   logic             mism;

   assign diff = (pin_in ^ core_out) & core_oe & CMP_MASK;
   assign mism = is_chk & (|diff);

   if (STICKY) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= err_q | mism;
      end
   end else begin : g_pulse
      always_ff @(posedge clk) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= mism;
      end
   end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
   import lc_pkg::*;
#(
   parameter int              WIDTH       = 32,
   parameter logic [WIDTH-1:0] EXEMPT_MASK = {1'b1, {(WIDTH-2){1'b0}}, 1'b1},
   parameter bit              STICKY      = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_chk,
   input  logic [WIDTH-1:0] core_out,
   input  logic [WIDTH-1:0] core_oe,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_oe,
   output logic             chk_err
);
   if (WIDTH < 2) begin : g_bad_width
      $error("lockstep_cmp: WIDTH must be at least 2");
   end
   if (&EXEMPT_MASK) begin : g_bad_mask
      $error("lockstep_cmp: EXEMPT_MASK leaves no bit to compare");
   end

   role_e role_q;
   logic  is_chk;

   assign is_chk = (role_q == ROLE_CHECKER);

   lc_role u_role (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_chk (strap_chk),
      .role_q    (role_q)
   );

   lc_drive #(.WIDTH(WIDTH), .EXEMPT_MASK(EXEMPT_MASK)) u_drive (
      .is_chk  (is_chk),
      .core_oe (core_oe),
      .pin_oe  (pin_oe)
   );

   lc_compare #(.WIDTH(WIDTH), .EXEMPT_MASK(EXEMPT_MASK), .STICKY(STICKY)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_chk   (is_chk),
      .core_out (core_out),
      .core_oe  (core_oe),
      .pin_in   (pin_in),
      .err_q    (chk_err)
   );
endmodule

// File: rtl/lc_checker.sv
module lc_checker
   import lc_pkg::*;
#(
   parameter int              WIDTH       = 32,
   parameter logic [WIDTH-1:0] EXEMPT_MASK = '0,
   parameter bit              STICKY      = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input role_e            role_q,
   input logic [WIDTH-1:0] core_out,
   input logic [WIDTH-1:0] core_oe,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pin_oe,
   input logic             chk_err
);
   logic seen_bad;
   assign seen_bad = |((pin_in ^ core_out) & core_oe & ~EXEMPT_MASK);

   // R2
   role_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(role_q));

   // R3
   master_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q == ROLE_MASTER) |-> (pin_oe == core_oe));

   // R4
   checker_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q == ROLE_CHECKER) |-> ((pin_oe & ~EXEMPT_MASK) == '0));

   // R5
   mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((role_q == ROLE_CHECKER) && seen_bad) |=> chk_err);

   // R8
   master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q == ROLE_MASTER) |-> !chk_err);

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> !chk_err);

   if (!STICKY) begin : g_pulse_chk
      // R10
      pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !seen_bad |=> !chk_err);
   end else begin : g_hold_chk
      // R10
      hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         chk_err |=> chk_err);
   end
endmodule

bind lockstep_cmp lc_checker #(
   .WIDTH(WIDTH), .EXEMPT_MASK(EXEMPT_MASK), .STICKY(STICKY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .role_q   (role_q),
   .core_out (core_out),
   .core_oe  (core_oe),
   .pin_in   (pin_in),
   .pin_oe   (pin_oe),
   .chk_err  (chk_err)
);

// File: tb/lockstep_cmp_tb.sv
module lockstep_cmp_tb;
   localparam int CLK_P = 10;
   localparam int W = 8;
   localparam logic [W-1:0] EXM = 8'h81;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         strap_chk = 1'b0;
   logic [W-1:0] core_out = '0;
   logic [W-1:0] core_oe = '0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_oe, pin_oe_s;
   logic         chk_err, chk_err_s;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   lockstep_cmp #(.WIDTH(W), .EXEMPT_MASK(EXM), .STICKY(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_chk(strap_chk), .core_out(core_out),
      .core_oe(core_oe), .pin_in(pin_in), .pin_oe(pin_oe), .chk_err(chk_err));

   lockstep_cmp #(.WIDTH(W), .EXEMPT_MASK(EXM), .STICKY(1'b1)) u_dut_sticky (
      .clk(clk), .rst_n(rst_n), .strap_chk(strap_chk), .core_out(core_out),
      .core_oe(core_oe), .pin_in(pin_in), .pin_oe(pin_oe_s), .chk_err(chk_err_s));

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic role);
      rst_n = 1'b0;
      strap_chk = role;
      core_oe = '0; core_out = '0; pin_in = '0;
      step(); step(); step();
      rst_n = 1'b1;
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(); step();
      check(chk_err == 1'b0, "R9 err low in reset", chk_err, 0);
      check(chk_err_s == 1'b0, "R9 sticky err low in reset", chk_err_s, 0);
   endtask

   task automatic t_master();
      do_reset(1'b0);
      core_oe = 8'hFF; #1;
      check(pin_oe == 8'hFF, "R1 R3 master drives all", pin_oe, 8'hFF);
      core_oe = 8'h5A; #1;
      check(pin_oe == 8'h5A, "R3 master follows oe", pin_oe, 8'h5A);
      core_out = 8'h0F; pin_in = 8'hF0;
      step();
      check(chk_err == 1'b0, "R8 master no compare", chk_err, 0);
      step();
      check(chk_err_s == 1'b0, "R8 master sticky quiet", chk_err_s, 0);
      strap_chk = 1'b1;
      step(); step();
      core_oe = 8'h3C; #1;
      check(pin_oe == 8'h3C, "R2 strap ignored in master", pin_oe, 8'h3C);
   endtask

   task automatic t_checker();
      do_reset(1'b1);
      core_oe = 8'hFF; #1;
      check(pin_oe == 8'h81, "R1 R4 checker floats nonexempt", pin_oe, 8'h81);
      core_oe = 8'h7E; #1;
      check(pin_oe == 8'h00, "R4 exempt bits off", pin_oe, 8'h00);
      core_oe = 8'hFF; core_out = 8'hA5; pin_in = 8'hA5;
      step();
      check(chk_err == 1'b0, "R5 match no error", chk_err, 0);
      pin_in = 8'hAD;
      step();
      check(chk_err == 1'b1, "R5 mismatch flagged", chk_err, 1);
      check(chk_err_s == 1'b1, "R5 sticky flagged", chk_err_s, 1);
      pin_in = 8'hA5;
      step();
      check(chk_err == 1'b0, "R10 pulse clears", chk_err, 0);
      check(chk_err_s == 1'b1, "R10 sticky holds", chk_err_s, 1);
      step();
      check(chk_err_s == 1'b1, "R10 sticky still holds", chk_err_s, 1);
      strap_chk = 1'b0;
      step();
      check(pin_oe == 8'h81, "R2 strap ignored in checker", pin_oe, 8'h81);
   endtask

   task automatic t_masking();
      do_reset(1'b1);
      check(chk_err_s == 1'b0, "R10 sticky cleared by reset", chk_err_s, 0);
      core_out = 8'h00; core_oe = 8'hF7; pin_in = 8'h08;
      step();
      check(chk_err == 1'b0, "R6 disabled bit skipped", chk_err, 0);
      core_oe = 8'hFF; pin_in = 8'h81;
      step();
      check(chk_err == 1'b0, "R7 exempt bits skipped", chk_err, 0);
      check(chk_err_s == 1'b0, "R7 sticky exempt skipped", chk_err_s, 0);
      pin_in = 8'h40;
      step();
      check(chk_err == 1'b1, "R5 top compared bit", chk_err, 1);
      pin_in = 8'h02;
      step();
      check(chk_err == 1'b1, "R5 low compared bit", chk_err, 1);
      rst_n = 1'b0;
      step();
      check(chk_err == 1'b0, "R9 reset clears flag", chk_err, 0);
      check(chk_err_s == 1'b0, "R9 reset clears sticky", chk_err_s, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_master();
      t_checker();
      t_masking();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule